// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Engine

This block is the host side of a three-wire serial EEPROM link. It drives chip select, serial clock and serial data toward the memory, and it samples the memory's serial output. A short command port takes one request at a time. A request holds a command code, a word address, write data and a burst length. The engine turns the request into a serial frame. During reads it removes the single placeholder bit the memory sends first, and it returns each word on a one-cycle strobe. After a programming command it checks the memory's ready/busy line until the memory is ready or a time limit runs out.

The serial clock is a divided copy of the system clock. Each half period lasts `HALF_DIV` system clocks. Outgoing data changes while the serial clock is low. Incoming data is sampled on the cycle in which the serial clock goes high. `WORD_MODE` selects 16-bit words with 8 address bits, or 8-bit words with 9 address bits. `CS_LOW_CYC` sets how many system clocks select stays low before a status check. `POLL_LIMIT` sets how long the engine waits for ready.

Top module: `sereep_host`

## Requirements
- R1: After reset, `cs_o`, `sk_o` and `di_o` are low, `cmd_ready` is high, and `done`, `rd_valid` and `err` are low.
- R2: A request is taken only in a cycle with both `cmd_valid` and `cmd_ready` high. From the next cycle, `cmd_ready` stays low and no new request is taken until `done` has pulsed. `cmd_ready` is never high while `cs_o` is high.
- R3: Every frame goes out MSB first on `di_o`. It is a start bit of 1, then a two-bit opcode, then the address. The opcodes are read = 10, write = 01 and single-word erase = 11. Command codes on `cmd_op`: 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 erase-all, 6 write-all.
- R4: Enable, disable, erase-all and write-all are sent with opcode 00. The two address MSBs then carry 11, 00, 10 or 01 respectively, and the other address bits are sent as 0.
- R5: Write and write-all frames append the data word, MSB first, right after the address.
- R6: `sk_o` is high only while `cs_o` is high. Each high phase of `sk_o` lasts exactly `HALF_DIV` clocks. `di_o` does not change while `sk_o` stays high.
- R7: On a read, the first bit sampled after the address is dropped. Each following group of word-width bits is returned on `rd_data`, with a one-cycle `rd_valid` pulse.
- R8: A read with `cmd_len` = N returns N+1 words from consecutive addresses in one select period, with no placeholder bit between words. `cs_o` then falls.
- R9: After write, erase, erase-all or write-all, `cs_o` stays low for at least `CS_LOW_CYC` clocks. It is then raised, and `do_i` is sampled each clock. When `do_i` reads 1, `cs_o` falls and `done` pulses for one cycle.
- R10: If ready is not seen within `POLL_LIMIT` clocks of polling, `done` pulses with `err` high. `err` stays high until the next request is taken.
- R11: Read, enable and disable finish with `done` as soon as the frame ends, with no status phase. Select is raised only once for these commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Engine idle, request may be taken |
| cmd_op | input | 3 | Command code (see R3) |
| cmd_addr | input | AW | Word address |
| cmd_wdata | input | DW | Data for write and write-all |
| cmd_len | input | LEN_W | Read burst length minus one |
| rd_data | output | DW | Returned read word |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Status poll timed out |
| cs_o | output | 1 | Chip select to memory |
| sk_o | output | 1 | Serial clock to memory |
| di_o | output | 1 | Serial data to memory |
| do_i | input | 1 | Serial data and ready/busy from memory |

## Verification
A wrong bit counter or a wrong shift register shows up within a single frame. The memory model then decodes a different header, an opcode lands in the wrong place, or a write stores a different word that the next read-back exposes. If the placeholder bit is not dropped, or is dropped again between burst words, every returned word is shifted by one bit, and the scoreboard reports this at the first `rd_valid` strobe. A wrong sequencer state in the status phase shows up in the same request: the select-low gap is too short, select is raised an extra time or not at all, or `done` comes with the wrong `err` value.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

   typedef enum logic [2:0] {
      CMD_READ   = 3'd0,
      CMD_WRITE  = 3'd1,
      CMD_ERASE  = 3'd2,
      CMD_WREN   = 3'd3,
      CMD_WRDIS  = 3'd4,
      CMD_CLRALL = 3'd5,
      CMD_SETALL = 3'd6
   } cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SEND, ST_RECV, ST_TAIL, ST_CSLOW, ST_POLL
   } st_e;

   // two opcode bits following the start bit (R3, R4)
   function automatic logic [1:0] op_bits(input cmd_e c);
      case (c)
         CMD_READ:  return 2'b10;
         CMD_WRITE: return 2'b01;
         CMD_ERASE: return 2'b11;
         default:   return 2'b00;
      endcase
   endfunction

   // selector carried in the address MSBs of the 00 group (R4)
   function automatic logic [1:0] sel_bits(input cmd_e c);
      case (c)
         CMD_WREN:   return 2'b11;
         CMD_CLRALL: return 2'b10;
         CMD_SETALL: return 2'b01;
         default:    return 2'b00;
      endcase
   endfunction

   function automatic logic is_prog(input cmd_e c);
      return (c == CMD_WRITE) || (c == CMD_ERASE) ||
             (c == CMD_CLRALL) || (c == CMD_SETALL);
   endfunction

   function automatic logic has_data(input cmd_e c);
      return (c == CMD_WRITE) || (c == CMD_SETALL);
   endfunction

endpackage

// File: rtl/sereep_tick.sv
// Serial-clock phase generator: alternating low/high ticks every HALF_DIV clocks.
module sereep_tick #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic lo_t,
   output logic hi_t
);
   logic tick;
   logic ph;

   generate
      if (HALF_DIV < 1) begin : g_chk
         $error("sereep_tick: HALF_DIV must be at least 1");
      end
      if (HALF_DIV == 1) begin : g_fast
         assign tick = run;
      end else begin : g_div
         localparam int CW = $clog2(HALF_DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt <= '0;
            else if (!run)                       cnt <= '0;
            else if (cnt == CW'(HALF_DIV - 1))   cnt <= '0;
            else                                 cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == CW'(HALF_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ph <= 1'b0;
      else if (!run)  ph <= 1'b0;
      else if (tick)  ph <= ~ph;
   end

   assign lo_t = tick & ~ph;
   assign hi_t = tick &  ph;
endmodule

// File: rtl/sereep_timer.sv
// Loadable down-counter shared by the select-low gap and the poll limit.
module sereep_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] val,
   output logic          zero
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/sereep_host.sv
module sereep_host
   import sereep_pkg::*;
#(
   parameter bit WORD_MODE  = 1'b1,
   parameter int HALF_DIV   = 2,
   parameter int CS_LOW_CYC = 13,
   parameter int POLL_LIMIT = 4000,
   parameter int LEN_W      = 4,
   localparam int AW = WORD_MODE ? 8 : 9,
   localparam int DW = WORD_MODE ? 16 : 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [2:0]       cmd_op,
   input  logic [AW-1:0]    cmd_addr,
   input  logic [DW-1:0]    cmd_wdata,
   input  logic [LEN_W-1:0] cmd_len,
   output logic [DW-1:0]    rd_data,
   output logic             rd_valid,
   output logic             done,
   output logic             err,
   output logic             cs_o,
   output logic             sk_o,
   output logic             di_o,
   input  logic             do_i
);
   localparam int HW   = 3 + AW;
   localparam int FW   = HW + DW;
   localparam int BCW  = $clog2(FW + 1);
   localparam int RBW  = $clog2(DW);
   localparam int TMAX = (CS_LOW_CYC > POLL_LIMIT) ? CS_LOW_CYC : POLL_LIMIT;
   localparam int TCW  = $clog2(TMAX + 1);

   generate
      if (CS_LOW_CYC < 1 || POLL_LIMIT < 1 || LEN_W < 1) begin : g_chk
         $error("sereep_host: CS_LOW_CYC, POLL_LIMIT and LEN_W must be positive");
      end
   endgenerate

   st_e              state;
   logic [FW-1:0]    sreg;
   logic [BCW-1:0]   bcnt;
   logic [LEN_W-1:0] wcnt;
   logic [RBW-1:0]   rbit;
   logic [DW-1:0]    rbuf;
   logic             skip, prog, rd;
   logic             lo_t, hi_t, run;
   logic             t_load, tz;
   logic [TCW-1:0]   t_val;
   logic             poll_phase;

   // request decode and frame assembly (R3, R4, R5)
   cmd_e           c;
   logic [AW-1:0]  afield;
   logic [DW-1:0]  dfield;
   logic [FW-1:0]  frame;
   logic [BCW-1:0] flen;

   always_comb begin
      c      = cmd_e'(cmd_op);
      afield = (op_bits(c) == 2'b00) ? {sel_bits(c), {(AW-2){1'b0}}} : cmd_addr;
      dfield = has_data(c) ? cmd_wdata : '0;
      frame  = {1'b1, op_bits(c), afield, dfield};
      flen   = has_data(c) ? BCW'(FW) : BCW'(HW);
   end

   assign run = (state == ST_SEND) || (state == ST_RECV) || (state == ST_TAIL);

   sereep_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run), .lo_t(lo_t), .hi_t(hi_t)
   );

   assign t_load = ((state == ST_TAIL) && lo_t && prog) || ((state == ST_CSLOW) && tz);
   assign t_val  = (state == ST_TAIL) ? TCW'(CS_LOW_CYC - 1) : TCW'(POLL_LIMIT - 1);

   sereep_timer #(.CW(TCW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .val(t_val), .zero(tz)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cs_o     <= 1'b0;
         sk_o     <= 1'b0;
         di_o     <= 1'b0;
         sreg     <= '0;
         bcnt     <= '0;
         wcnt     <= '0;
         rbit     <= '0;
         rbuf     <= '0;
         skip     <= 1'b0;
         prog     <= 1'b0;
         rd       <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         done     <= 1'b0;
         rd_valid <= 1'b0;
         unique case (state)
            ST_IDLE: if (cmd_valid) begin
               state <= ST_SEND;
               cs_o  <= 1'b1;
               sreg  <= frame;
               bcnt  <= flen;
               wcnt  <= cmd_len;
               prog  <= is_prog(c);
               rd    <= (c == CMD_READ);
               err   <= 1'b0;
            end
            ST_SEND: begin
               if (lo_t) begin
                  sk_o <= 1'b0;
                  di_o <= sreg[FW-1];
                  sreg <= {sreg[FW-2:0], 1'b0};
               end
               if (hi_t) begin
                  sk_o <= 1'b1;
                  bcnt <= bcnt - 1'b1;
                  if (bcnt == BCW'(1)) begin
                     state <= rd ? ST_RECV : ST_TAIL;
                     skip  <= 1'b1;
                     rbit  <= '0;
                  end
               end
            end
            ST_RECV: begin
               if (lo_t) begin
                  sk_o <= 1'b0;
                  di_o <= 1'b0;
               end
               if (hi_t) begin
                  sk_o <= 1'b1;
                  if (skip) begin
                     skip <= 1'b0;                 // placeholder bit (R7)
                  end else begin
                     rbuf <= {rbuf[DW-2:0], do_i};
                     if (rbit == RBW'(DW - 1)) begin
                        rbit     <= '0;
                        rd_data  <= {rbuf[DW-2:0], do_i};
                        rd_valid <= 1'b1;
                        if (wcnt == '0) state <= ST_TAIL;
                        else            wcnt  <= wcnt - 1'b1;   // R8 burst
                     end else begin
                        rbit <= rbit + 1'b1;
                     end
                  end
               end
            end
            ST_TAIL: if (lo_t) begin
               sk_o <= 1'b0;
               cs_o <= 1'b0;
               di_o <= 1'b0;
               if (prog) state <= ST_CSLOW;
               else begin
                  done  <= 1'b1;                   // R11
                  state <= ST_IDLE;
               end
            end
            ST_CSLOW: if (tz) begin
               cs_o  <= 1'b1;
               state <= ST_POLL;
            end
            ST_POLL: begin
               if (do_i) begin
                  cs_o  <= 1'b0;
                  done  <= 1'b1;                   // R9
                  state <= ST_IDLE;
               end else if (tz) begin
                  cs_o  <= 1'b0;
                  done  <= 1'b1;
                  err   <= 1'b1;                   // R10
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cmd_ready  = (state == ST_IDLE);
   assign poll_phase = (state == ST_POLL);
endmodule

// File: rtl/sereep_host_chk.sv
module sereep_host_chk #(
   parameter int CS_LOW_CYC = 13
) (
   input logic clk,
   input logic rst_n,
   input logic cs,
   input logic sk,
   input logic di,
   input logic done,
   input logic err,
   input logic rd_valid,
   input logic cmd_valid,
   input logic cmd_ready,
   input logic in_poll
);
   logic [15:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                low_run <= '0;
      else if (cs)               low_run <= '0;
      else if (low_run != '1)    low_run <= low_run + 1'b1;
   end

   assert_sk_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> !sk);

   assert_di_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sk && $past(sk)) |-> $stable(di));

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> (!cmd_ready && cs));

   assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !cs);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cs) && in_poll) |-> (low_run >= 16'(CS_LOW_CYC)));

   assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);

   assert_rdv_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> cs);
endmodule

bind sereep_host sereep_host_chk #(.CS_LOW_CYC(CS_LOW_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs(cs_o), .sk(sk_o), .di(di_o),
   .done(done), .err(err), .rd_valid(rd_valid),
   .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .in_poll(poll_phase)
);

// File: tb/sereep_host_bench.sv
module sereep_host_bench;
   import sereep_pkg::*;

   localparam int HALF_DIV = 2;
   localparam int CSLOW    = 13;
   localparam int POLL     = 300;
   localparam int BUSY     = 40;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [2:0]  cmd_op = '0;
   logic [7:0]  cmd_addr = '0;
   logic [15:0] cmd_wdata = '0;
   logic [3:0]  cmd_len = '0;
   logic [15:0] rd_data;
   logic        rd_valid, done, err, cs_o, sk_o, di_o, do_i;
   logic        stuck = 1'b0;

   sereep_host #(.WORD_MODE(1'b1), .HALF_DIV(HALF_DIV), .CS_LOW_CYC(CSLOW),
                 .POLL_LIMIT(POLL), .LEN_W(4)) u_sereep_host (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .cmd_len(cmd_len), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
      .err(err), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o), .do_i(do_i)
   );

   function automatic logic [15:0] init_word(input int i);
      return {8'(i) ^ 8'h5A, 8'(i)};
   endfunction

   // ---------------- memory model ----------------
   logic [15:0] mem [0:255];
   logic        sk_q, cs_q, do_r, m_status;
   int          m_busy;
   logic [26:0] rx;
   logic [10:0] hdr;
   int          nb, bp;
   logic        outm, en, go;
   logic [7:0]  ptr, ma;
   logic [15:0] word;

   assign do_i = m_status ? ((m_busy == 0) && !stuck) : do_r;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] = init_word(i);
         sk_q <= 1'b0; cs_q <= 1'b0; do_r <= 1'b0; m_status <= 1'b0; m_busy <= 0;
         rx = '0; hdr = '0; nb = 0; bp = 15; outm = 1'b0; en = 1'b0; ptr = '0; word = '0;
      end else begin
         sk_q <= sk_o;
         cs_q <= cs_o;
         if (m_busy != 0) m_busy <= m_busy - 1;
         if (cs_o && sk_o && !sk_q) begin
            if (!outm) begin
               rx = {rx[25:0], di_o};
               nb++;
               if (nb == 11) begin
                  hdr = rx[10:0];
                  if (rx[9:8] == 2'b10) begin
                     outm = 1'b1; do_r <= 1'b0; ptr = rx[7:0]; word = mem[ptr]; bp = 15;
                  end
               end
            end else begin
               do_r <= word[bp];
               if (bp == 0) begin ptr = ptr + 1'b1; word = mem[ptr]; bp = 15; end
               else bp--;
            end
         end
         if (!cs_o && cs_q) begin
            if (m_status) m_status <= 1'b0;
            else begin
               go = 1'b0;
               ma = hdr[7:0];
               if (nb == 11 && hdr[9:8] == 2'b11) begin
                  if (en) mem[ma] = 16'hFFFF;
                  go = 1'b1;
               end else if (nb == 27 && hdr[9:8] == 2'b01) begin
                  if (en) mem[ma] = rx[15:0];
                  go = 1'b1;
               end else if (nb == 11 && hdr[9:8] == 2'b00) begin
                  case (ma[7:6])
                     2'b11: en = 1'b1;
                     2'b00: en = 1'b0;
                     2'b10: begin
                        if (en) for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
                        go = 1'b1;
                     end
                     default: ;
                  endcase
               end else if (nb == 27 && hdr[9:8] == 2'b00 && ma[7:6] == 2'b01) begin
                  if (en) for (int i = 0; i < 256; i++) mem[i] = rx[15:0];
                  go = 1'b1;
               end
               if (go) begin
                  m_status <= 1'b1;
                  m_busy   <= en ? BUSY : 0;
               end
            end
            nb = 0; outm = 1'b0; rx = '0;
         end
      end
   end

   // ---------------- monitor / scoreboard ----------------
   logic [15:0] exp_q [$];
   int  mon_checks = 0, mon_fails = 0;
   int  cs_rises = 0, rdv_cnt = 0, low_run = 0, last_low = 0, hi_run = 0;
   int  di_bad = 0, skw_bad = 0, rdy_bad = 0;
   logic sk_p = 1'b0, cs_p = 1'b0, di_p = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cs_o && !cs_p) begin cs_rises++; last_low = low_run; end
         if (!cs_o) low_run++; else low_run = 0;
         if (sk_o && sk_p && di_o != di_p) di_bad++;
         if (sk_o) hi_run++;
         else begin
            if (sk_p && hi_run != HALF_DIV) skw_bad++;
            hi_run = 0;
         end
         if (cs_o && cmd_ready) rdy_bad++;
         if (rd_valid) begin
            rdv_cnt++;
            mon_checks++;
            if (exp_q.size() == 0) begin
               mon_fails++;
               $display("FAIL R7 unexpected word actual=%h expected=none", rd_data);
            end else begin
               logic [15:0] ew;
               ew = exp_q.pop_front();
               if (rd_data !== ew) begin
                  mon_fails++;
                  $display("FAIL R7/R8 read word actual=%h expected=%h", rd_data, ew);
               end
            end
         end
      end
      sk_p = sk_o; cs_p = cs_o; di_p = di_o;
   end

   // ---------------- driver ----------------
   int checks = 0, fails = 0;
   logic [15:0] shadow [0:255];
   logic        sh_en;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_cmd(input cmd_e op, input logic [7:0] a, input logic [15:0] d,
                          input logic [3:0] len, output logic e, output int rises, output int words);
      int r0, w0;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      r0 = cs_rises; w0 = rdv_cnt;
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_len = len;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!done) @(negedge clk);
      e = err; rises = cs_rises - r0; words = rdv_cnt - w0;
   endtask

   task automatic do_read(input logic [7:0] a, input logic [3:0] len);
      logic e; int rs, ws;
      for (int k = 0; k <= int'(len); k++) exp_q.push_back(shadow[8'(a + 8'(k))]);
      run_cmd(CMD_READ, a, 16'h0, len, e, rs, ws);
      chk(hdr == {3'b110, a}, "R3 read header", 32'(hdr), 32'({3'b110, a}));
      chk(ws == int'(len) + 1, "R8 word count", 32'(ws), 32'(int'(len) + 1));
      chk(rs == 1, "R11 read select count", 32'(rs), 32'd1);
      chk(e == 1'b0, "R10 err on read", 32'(e), 32'd0);
   endtask

   task automatic do_prog(input cmd_e op, input logic [7:0] a, input logic [15:0] d,
                          input logic [10:0] exp_hdr, input string tag);
      logic e; int rs, ws;
      run_cmd(op, a, d, 4'd0, e, rs, ws);
      chk(hdr == exp_hdr, tag, 32'(hdr), 32'(exp_hdr));
      chk(rs == 2, "R9 select raised for poll", 32'(rs), 32'd2);
      chk(last_low >= CSLOW, "R9 select low gap", 32'(last_low), 32'(CSLOW));
      chk(e == 1'b0, "R9 done without err", 32'(e), 32'd0);
      if (sh_en) begin
         case (op)
            CMD_WRITE:  shadow[a] = d;
            CMD_ERASE:  shadow[a] = 16'hFFFF;
            CMD_CLRALL: for (int i = 0; i < 256; i++) shadow[i] = 16'hFFFF;
            CMD_SETALL: for (int i = 0; i < 256; i++) shadow[i] = d;
            default: ;
         endcase
      end
   endtask

   task automatic do_ctl(input cmd_e op, input logic [10:0] exp_hdr, input string tag);
      logic e; int rs, ws;
      run_cmd(op, 8'hA5, 16'h0, 4'd0, e, rs, ws);
      chk(hdr == exp_hdr, tag, 32'(hdr), 32'(exp_hdr));
      chk(rs == 1, "R11 control select count", 32'(rs), 32'd1);
      sh_en = (op == CMD_WREN);
   endtask

   initial begin
      logic e; int rs, ws;
      for (int i = 0; i < 256; i++) shadow[i] = init_word(i);
      sh_en = 1'b0;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk({cs_o, sk_o, di_o} == 3'b000, "R1 serial pins", 32'({cs_o, sk_o, di_o}), 32'd0);
      chk({cmd_ready, done, rd_valid, err} == 4'b1000, "R1 handshake outputs",
          32'({cmd_ready, done, rd_valid, err}), 32'h8);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      do_read(8'd5, 4'd0);
      // write while disabled: frame still sent and polled, memory unchanged
      do_prog(CMD_WRITE, 8'd3, 16'hBEEF, 11'b1_01_00000011, "R3 write header");
      do_read(8'd3, 4'd0);
      do_ctl(CMD_WREN, 11'b1_00_11000000, "R4 enable header");
      do_prog(CMD_WRITE, 8'd3, 16'hBEEF, 11'b1_01_00000011, "R3 write header");
      chk(rx == 27'd0, "R5 model frame closed", 32'(rx), 32'd0);
      do_read(8'd3, 4'd0);                                   // R5 data MSB first
      do_read(8'd2, 4'd3);                                   // R8 burst of four
      do_prog(CMD_ERASE, 8'd4, 16'h0, 11'b1_11_00000100, "R3 erase header");
      do_read(8'd4, 4'd0);
      do_prog(CMD_SETALL, 8'd0, 16'h3C3C, 11'b1_00_01000000, "R4 write-all header");
      do_read(8'd254, 4'd2);
      do_prog(CMD_CLRALL, 8'd0, 16'h0, 11'b1_00_10000000, "R4 erase-all header");
      do_read(8'd7, 4'd0);
      do_ctl(CMD_WRDIS, 11'b1_00_00000000, "R4 disable header");
      do_prog(CMD_WRITE, 8'd9, 16'h1111, 11'b1_01_00001001, "R3 write header");
      do_read(8'd9, 4'd0);

      // R10 poll timeout
      do_ctl(CMD_WREN, 11'b1_00_11000000, "R4 enable header");
      stuck = 1'b1;
      run_cmd(CMD_WRITE, 8'd1, 16'h0000, 4'd0, e, rs, ws);
      chk(e == 1'b1, "R10 err after timeout", 32'(e), 32'd1);
      shadow[1] = 16'h0000;
      stuck = 1'b0;
      repeat (BUSY + 5) @(negedge clk);
      chk(err == 1'b1, "R10 err held while idle", 32'(err), 32'd1);
      do_read(8'd1, 4'd0);                                   // err cleared on accept

      repeat (5) @(negedge clk);
      chk(di_bad == 0, "R6 di stable while sk high", 32'(di_bad), 32'd0);
      chk(skw_bad == 0, "R6 sk high width", 32'(skw_bad), 32'd0);
      chk(rdy_bad == 0, "R2 ready while busy", 32'(rdy_bad), 32'd0);
      chk(exp_q.size() == 0, "R7 all words returned", 32'(exp_q.size()), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + mon_checks, fails + mon_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + mon_checks + 1, fails + mon_fails + 1);
      $finish;
   end
endmodule